// File: doc/BRIEF.md
# Auto-Increment Table Readback Port

This block gives a host a way to read a 16-entry table of 64-bit words through four 16-bit I/O registers. The host first writes a start address into I/O register 0 and issues a set-pointer operation. It then issues fast-read operations. Each fast read copies the entry at the pointer into the four I/O registers and advances the pointer. A run of back-to-back reads therefore walks through contiguous entries and wraps at the end of the table.

Both operations are legal only while the entry queue feeding the table is empty. An operation issued while the queue holds work is refused. The refusal leaves the pointer and the I/O registers untouched, writes a fixed error code, latches an error flag, and raises an interrupt if the host has enabled it. The table itself lives elsewhere. The block sees it as a combinational read port with an address out and a data word in.

Top module: `tbl_readback_port`

## Requirements
- R1: While reset is held, the read pointer, all four I/O registers, the error code, the interrupt-enable register and the flag register's error bit are zero, and `irq` is low.
- R2: An operation with `op_code` 2'b01 (set pointer), strobed while `queue_empty` is high, loads the low 14 bits of I/O register 0 into the read pointer at that clock edge.
- R3: An operation with `op_code` 2'b10 (fast read), strobed while `queue_empty` is high, loads the table entry at address `rd_ptr mod 16` into the I/O registers at that edge. I/O register 3 bits 15..0 hold entry bits 63..48 and I/O register 0 bits 15..0 hold entry bits 15..0. `io_regs` is {reg3, reg2, reg1, reg0}.
- R4: An accepted fast read sets the pointer to ((rd_ptr mod 16) + 1) mod 16, with bits 13..4 cleared. Back-to-back reads return contiguous entries, and entry 15 is followed by entry 0.
- R5: Bit 4 of `flags` equals `queue_empty` in every cycle.
- R6: A set-pointer or fast-read operation strobed while `queue_empty` is low writes 16'hFFFC to `err_code` and sets bit 7 of `flags` at that edge.
- R7: A refused operation leaves `rd_ptr` and `io_regs` unchanged.
- R8: `irq` is high exactly when bit 7 of `flags` and bit 7 of `irq_en` are both set. `irq_en` is loaded from `irq_en_data` when `irq_en_wr` is high.
- R9: The error flag stays set until a write with `flag_clr_en` high and bit 7 of `flag_clr_data` set. A clear with that bit low has no effect. A new error in the same cycle as a clear leaves the flag set.
- R10: A host write (`io_wr_en`, `io_wr_sel` picks the register) updates one I/O register. An accepted fast read in the same cycle takes priority over it. `op_code` values 2'b00 and 2'b11 change neither the pointer, the I/O registers nor the error state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe, one cycle per operation |
| op_code | input | 2 | 01 set pointer, 10 fast read, others no-op |
| io_wr_en | input | 1 | Host write to one I/O register |
| io_wr_sel | input | 2 | I/O register index for the host write |
| io_wr_data | input | 16 | Host write data |
| io_regs | output | 64 | I/O registers 3..0 concatenated |
| queue_empty | input | 1 | Entry queue is empty |
| tbl_addr | output | 4 | Table read address |
| tbl_data | input | 64 | Table entry at `tbl_addr` |
| rd_ptr | output | 14 | Read pointer |
| flag_clr_en | input | 1 | Write-one-to-clear strobe for the flags |
| flag_clr_data | input | 16 | Clear mask, bit 7 clears the error flag |
| flags | output | 16 | Bit 7 error, bit 4 queue empty, others zero |
| err_code | output | 16 | Last error code |
| irq_en_wr | input | 1 | Load the interrupt-enable register |
| irq_en_data | input | 16 | Interrupt-enable write data |
| irq_en | output | 16 | Interrupt-enable register, bit 7 gates the error |
| irq | output | 1 | Interrupt request |

## Verification
The bench reads a burst that runs from entry 14 across the end of the table. A pointer that kept its upper bits or failed to wrap would return the wrong entries there. Operations are refused while the queue is busy, and the bench then checks that neither the pointer nor the registers moved; a design that gated only the error path would still advance or overwrite them. It also drives collisions in the same cycle: a clear against a new error, and a host write against a fast read. A wrong priority shows up as a lost error or a stale register. A start address with its upper bits set checks that the pointer load keeps exactly 14 bits and that the table address uses only the low four.

// File: rtl/rdb_pkg.sv
package rdb_pkg;

  typedef enum logic [1:0] {
    OP_NOP    = 2'b00,
    OP_SETPTR = 2'b01,
    OP_FREAD  = 2'b10,
    OP_RSVD   = 2'b11
  } rdb_op_e;

  localparam logic [15:0] ERR_QUEUE_BUSY = 16'hFFFC;
  localparam int          FLAG_QE_BIT    = 4;
  localparam int          FLAG_ERR_BIT   = 7;
  localparam int          IRQ_ERR_BIT    = 7;

endpackage

// File: rtl/rdb_decode.sv
module rdb_decode
  import rdb_pkg::*;
(
  input  logic       op_valid,
  input  logic [1:0] op_code,
  input  logic       queue_empty,
  output logic       set_ok,
  output logic       read_ok,
  output logic       reject
);

  logic is_set;
  logic is_read;

  always_comb begin
    is_set  = op_valid && (op_code == OP_SETPTR);
    is_read = op_valid && (op_code == OP_FREAD);
    set_ok  = is_set && queue_empty;
    read_ok = is_read && queue_empty;
    reject  = (is_set || is_read) && !queue_empty;
  end

endmodule

// File: rtl/rdb_ptr.sv
module rdb_ptr #(
  parameter int PTR_W  = 14,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [PTR_W-1:0]  load_val,
  input  logic              inc_en,
  output logic [PTR_W-1:0]  ptr,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [PTR_W-1:0]  ptr_q;
  logic [PTR_W-1:0]  ptr_d;
  logic [ADDR_W-1:0] addr_inc;
  logic              ptr_en;

  always_comb begin
    addr     = ptr_q[ADDR_W-1:0];
    addr_inc = (addr == LAST_ADDR) ? '0 : addr + 1'b1;
    ptr_en   = load_en || inc_en;
    if (load_en) begin
      ptr_d = load_val;
    end else begin
      ptr_d = {{(PTR_W-ADDR_W){1'b0}}, addr_inc};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/rdb_ioregs.sv
module rdb_ioregs #(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 4,
  parameter int SEL_W     = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_en,
  input  logic [WORD_W*NUM_WORDS-1:0] load_entry,
  input  logic                        host_wr,
  input  logic [SEL_W-1:0]            host_sel,
  input  logic [WORD_W-1:0]           host_data,
  output logic [WORD_W*NUM_WORDS-1:0] regs
);

  for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_d;
    logic              word_hit;
    logic              word_en;

    always_comb begin
      word_hit = host_wr && (host_sel == SEL_W'(gi));
      word_en  = load_en || word_hit;
      if (load_en) begin
        word_d = load_entry[gi*WORD_W +: WORD_W];
      end else begin
        word_d = host_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (word_en) begin
        word_q <= word_d;
      end
    end

    assign regs[gi*WORD_W +: WORD_W] = word_q;
  end

endmodule

// File: rtl/rdb_status.sv
module rdb_status
  import rdb_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_set,
  input  logic              queue_empty,
  input  logic              clr_en,
  input  logic [WORD_W-1:0] clr_data,
  input  logic              irq_en_wr,
  input  logic [WORD_W-1:0] irq_en_data,
  output logic [WORD_W-1:0] err_code,
  output logic [WORD_W-1:0] flags,
  output logic [WORD_W-1:0] irq_en,
  output logic              irq
);

  localparam logic [WORD_W-1:0] ERR_MASK = WORD_W'(1) << FLAG_ERR_BIT;

  logic [WORD_W-1:0] code_q;
  logic              err_q;
  logic              err_d;
  logic              err_clr;
  logic              err_en;
  logic [WORD_W-1:0] ien_q;

  always_comb begin
    err_clr = clr_en && (|(clr_data & ERR_MASK));
    err_en  = err_set || err_clr;
    err_d   = err_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (err_set) begin
      code_q <= ERR_QUEUE_BUSY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
    end else if (irq_en_wr) begin
      ien_q <= irq_en_data;
    end
  end

  always_comb begin
    flags               = '0;
    flags[FLAG_QE_BIT]  = queue_empty;
    flags[FLAG_ERR_BIT] = err_q;
    err_code            = code_q;
    irq_en              = ien_q;
    irq                 = err_q && ien_q[IRQ_ERR_BIT];
  end

endmodule

// File: rtl/tbl_readback_port.sv
module tbl_readback_port #(
  parameter int DEPTH     = 16,
  parameter int PTR_W     = 14,
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 4,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int SEL_W    = $clog2(NUM_WORDS),
  localparam int ENTRY_W  = WORD_W * NUM_WORDS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [1:0]         op_code,
  input  logic               io_wr_en,
  input  logic [SEL_W-1:0]   io_wr_sel,
  input  logic [WORD_W-1:0]  io_wr_data,
  output logic [ENTRY_W-1:0] io_regs,
  input  logic               queue_empty,
  output logic [ADDR_W-1:0]  tbl_addr,
  input  logic [ENTRY_W-1:0] tbl_data,
  output logic [PTR_W-1:0]   rd_ptr,
  input  logic               flag_clr_en,
  input  logic [WORD_W-1:0]  flag_clr_data,
  output logic [WORD_W-1:0]  flags,
  output logic [WORD_W-1:0]  err_code,
  input  logic               irq_en_wr,
  input  logic [WORD_W-1:0]  irq_en_data,
  output logic [WORD_W-1:0]  irq_en,
  output logic               irq
);

  logic set_ok;
  logic read_ok;
  logic reject;

  rdb_decode u_decode (
    .op_valid    (op_valid),
    .op_code     (op_code),
    .queue_empty (queue_empty),
    .set_ok      (set_ok),
    .read_ok     (read_ok),
    .reject      (reject)
  );

  rdb_ptr #(
    .PTR_W  (PTR_W),
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
  ) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (set_ok),
    .load_val (io_regs[PTR_W-1:0]),
    .inc_en   (read_ok),
    .ptr      (rd_ptr),
    .addr     (tbl_addr)
  );

  rdb_ioregs #(
    .WORD_W    (WORD_W),
    .NUM_WORDS (NUM_WORDS),
    .SEL_W     (SEL_W)
  ) u_ioregs (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (read_ok),
    .load_entry (tbl_data),
    .host_wr    (io_wr_en),
    .host_sel   (io_wr_sel),
    .host_data  (io_wr_data),
    .regs       (io_regs)
  );

  rdb_status #(
    .WORD_W (WORD_W)
  ) u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_set     (reject),
    .queue_empty (queue_empty),
    .clr_en      (flag_clr_en),
    .clr_data    (flag_clr_data),
    .irq_en_wr   (irq_en_wr),
    .irq_en_data (irq_en_data),
    .err_code    (err_code),
    .flags       (flags),
    .irq_en      (irq_en),
    .irq         (irq)
  );

endmodule

// File: rtl/rdb_checker.sv
module rdb_checker
  import rdb_pkg::*;
#(
  parameter int PTR_W   = 14,
  parameter int ADDR_W  = 4,
  parameter int ENTRY_W = 64,
  parameter int WORD_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               op_valid,
  input logic [1:0]         op_code,
  input logic               io_wr_en,
  input logic               queue_empty,
  input logic [ENTRY_W-1:0] io_regs,
  input logic [ENTRY_W-1:0] tbl_data,
  input logic [PTR_W-1:0]   rd_ptr,
  input logic [WORD_W-1:0]  flags,
  input logic [WORD_W-1:0]  err_code,
  input logic [WORD_W-1:0]  irq_en,
  input logic               irq
);

  logic is_op;
  logic rd_acc;
  logic set_acc;
  logic refused;

  always_comb begin
    is_op   = op_valid && (op_code == OP_SETPTR || op_code == OP_FREAD);
    rd_acc  = op_valid && (op_code == OP_FREAD) && queue_empty;
    set_acc = op_valid && (op_code == OP_SETPTR) && queue_empty;
    refused = is_op && !queue_empty;
  end

  a_r2_set_loads: assert property (@(posedge clk) disable iff (!rst_n)
    set_acc |=> rd_ptr == $past(io_regs[PTR_W-1:0]));

  a_r3_read_copies: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> io_regs == $past(tbl_data));

  a_r4_ptr_advances: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> (rd_ptr[ADDR_W-1:0] == ADDR_W'($past(rd_ptr[ADDR_W-1:0]) + 1'b1))
               && (rd_ptr[PTR_W-1:ADDR_W] == '0));

  a_r5_flag_mirrors_queue: assert property (@(posedge clk) disable iff (!rst_n)
    flags[FLAG_QE_BIT] == queue_empty);

  a_r6_error_reported: assert property (@(posedge clk) disable iff (!rst_n)
    refused |=> (err_code == ERR_QUEUE_BUSY) && flags[FLAG_ERR_BIT]);

  a_r7_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (refused && !io_wr_en) |=> $stable(rd_ptr) && $stable(io_regs));

  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (flags[FLAG_ERR_BIT] && irq_en[IRQ_ERR_BIT]));

endmodule

bind tbl_readback_port rdb_checker #(
  .PTR_W   (PTR_W),
  .ADDR_W  (ADDR_W),
  .ENTRY_W (ENTRY_W),
  .WORD_W  (WORD_W)
) u_chk (.*);

// File: tb/tbl_readback_port_tb.sv
module tbl_readback_port_tb;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [1:0]  op_code;
  logic        io_wr_en;
  logic [1:0]  io_wr_sel;
  logic [15:0] io_wr_data;
  logic [63:0] io_regs;
  logic        queue_empty;
  logic [3:0]  tbl_addr;
  logic [63:0] tbl_data;
  logic [13:0] rd_ptr;
  logic        flag_clr_en;
  logic [15:0] flag_clr_data;
  logic [15:0] flags;
  logic [15:0] err_code;
  logic        irq_en_wr;
  logic [15:0] irq_en_data;
  logic [15:0] irq_en;
  logic        irq;

  int n_checks;
  int n_fails;
  bit timed_out;

  tbl_readback_port u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_valid      (op_valid),
    .op_code       (op_code),
    .io_wr_en      (io_wr_en),
    .io_wr_sel     (io_wr_sel),
    .io_wr_data    (io_wr_data),
    .io_regs       (io_regs),
    .queue_empty   (queue_empty),
    .tbl_addr      (tbl_addr),
    .tbl_data      (tbl_data),
    .rd_ptr        (rd_ptr),
    .flag_clr_en   (flag_clr_en),
    .flag_clr_data (flag_clr_data),
    .flags         (flags),
    .err_code      (err_code),
    .irq_en_wr     (irq_en_wr),
    .irq_en_data   (irq_en_data),
    .irq_en        (irq_en),
    .irq           (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [63:0] entry_of(input logic [3:0] a);
    return {a, 12'hABC, 12'h8F0, a, 16'h4321 ^ {12'h0, a}, 12'h001, a};
  endfunction

  assign tbl_data = entry_of(tbl_addr);

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic do_op(input logic [1:0] code);
    @(negedge clk);
    op_valid = 1'b1;
    op_code  = code;
    @(negedge clk);
    op_valid = 1'b0;
    op_code  = 2'b00;
  endtask

  task automatic io_write(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    io_wr_en   = 1'b1;
    io_wr_sel  = sel;
    io_wr_data = data;
    @(negedge clk);
    io_wr_en   = 1'b0;
  endtask

  task automatic t_reset;
    chk_eq("R1 pointer", 64'(rd_ptr), 64'h0);
    chk_eq("R1 io regs", io_regs, 64'h0);
    chk_eq("R1 err code", 64'(err_code), 64'h0);
    chk_eq("R1 irq enable", 64'(irq_en), 64'h0);
    chk_eq("R1 err flag", 64'(flags[7]), 64'h0);
    chk_eq("R1 irq", 64'(irq), 64'h0);
  endtask

  task automatic t_set_and_read;
    io_write(2'd0, 16'hFFF5);
    do_op(2'b01);
    chk_eq("R2 set pointer keeps 14 bits", 64'(rd_ptr), 64'h3FF5);
    chk_eq("R2 table address low bits", 64'(tbl_addr), 64'h5);
    do_op(2'b10);
    chk_eq("R3 read entry 5", io_regs, entry_of(4'd5));
    chk_eq("R3 reg3 bit15 is entry MSB", 64'(io_regs[63]), 64'(entry_of(4'd5) >> 63));
    chk_eq("R4 pointer after read", 64'(rd_ptr), 64'h6);
    chk_eq("R5 flag queue empty", 64'(flags[4]), 64'h1);
  endtask

  task automatic t_burst_wrap;
    io_write(2'd0, 16'h000E);
    do_op(2'b01);
    chk_eq("R2 set pointer 14", 64'(rd_ptr), 64'hE);
    @(negedge clk);
    op_valid = 1'b1;
    op_code  = 2'b10;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk_eq("R3 burst entry", io_regs, entry_of(4'(14 + i)));
      chk_eq("R4 burst pointer wraps", 64'(rd_ptr), 64'((15 + i) % 16));
    end
    op_valid = 1'b0;
    op_code  = 2'b00;
  endtask

  task automatic t_reject;
    logic [63:0] regs_before;
    logic [13:0] ptr_before;
    regs_before = io_regs;
    ptr_before  = rd_ptr;
    @(negedge clk);
    queue_empty = 1'b0;
    #1;
    chk_eq("R5 flag queue busy", 64'(flags[4]), 64'h0);
    do_op(2'b10);
    chk_eq("R6 error code", 64'(err_code), 64'hFFFC);
    chk_eq("R6 error flag", 64'(flags[7]), 64'h1);
    chk_eq("R7 pointer held on refused read", 64'(rd_ptr), 64'(ptr_before));
    chk_eq("R7 io regs held on refused read", io_regs, regs_before);
    chk_eq("R8 irq masked", 64'(irq), 64'h0);
    do_op(2'b01);
    chk_eq("R7 pointer held on refused set", 64'(rd_ptr), 64'(ptr_before));
    chk_eq("R6 error code after refused set", 64'(err_code), 64'hFFFC);
    @(negedge clk);
    queue_empty = 1'b1;
  endtask

  task automatic t_irq_clear;
    @(negedge clk);
    irq_en_wr   = 1'b1;
    irq_en_data = 16'h0080;
    @(negedge clk);
    irq_en_wr   = 1'b0;
    chk_eq("R8 irq enable readback", 64'(irq_en), 64'h0080);
    chk_eq("R8 irq raised", 64'(irq), 64'h1);
    @(negedge clk);
    flag_clr_en   = 1'b1;
    flag_clr_data = 16'hFF7F;
    @(negedge clk);
    flag_clr_en   = 1'b0;
    chk_eq("R9 clear without bit7 ignored", 64'(flags[7]), 64'h1);
    @(negedge clk);
    flag_clr_en   = 1'b1;
    flag_clr_data = 16'h0080;
    @(negedge clk);
    flag_clr_en   = 1'b0;
    chk_eq("R9 w1c clears flag", 64'(flags[7]), 64'h0);
    chk_eq("R8 irq drops with flag", 64'(irq), 64'h0);
  endtask

  task automatic t_priority;
    logic [63:0] regs_before;
    logic [13:0] ptr_before;
    @(negedge clk);
    queue_empty   = 1'b0;
    op_valid      = 1'b1;
    op_code       = 2'b10;
    flag_clr_en   = 1'b1;
    flag_clr_data = 16'h0080;
    @(negedge clk);
    op_valid      = 1'b0;
    flag_clr_en   = 1'b0;
    queue_empty   = 1'b1;
    chk_eq("R9 error wins over clear", 64'(flags[7]), 64'h1);
    io_write(2'd0, 16'h0003);
    do_op(2'b01);
    @(negedge clk);
    op_valid   = 1'b1;
    op_code    = 2'b10;
    io_wr_en   = 1'b1;
    io_wr_sel  = 2'd2;
    io_wr_data = 16'hDEAD;
    @(negedge clk);
    op_valid   = 1'b0;
    io_wr_en   = 1'b0;
    chk_eq("R10 fast read beats host write", io_regs, entry_of(4'd3));
    io_write(2'd1, 16'hBEEF);
    chk_eq("R10 host write reg1", 64'(io_regs[31:16]), 64'hBEEF);
    regs_before = io_regs;
    ptr_before  = rd_ptr;
    do_op(2'b11);
    do_op(2'b00);
    chk_eq("R10 reserved op leaves pointer", 64'(rd_ptr), 64'(ptr_before));
    chk_eq("R10 reserved op leaves io regs", io_regs, regs_before);
    chk_eq("R10 reserved op no error code change", 64'(err_code), 64'hFFFC);
  endtask

  initial begin
    n_checks      = 0;
    n_fails       = 0;
    timed_out     = 1'b0;
    rst_n         = 1'b0;
    op_valid      = 1'b0;
    op_code       = 2'b00;
    io_wr_en      = 1'b0;
    io_wr_sel     = 2'd0;
    io_wr_data    = 16'h0;
    queue_empty   = 1'b1;
    flag_clr_en   = 1'b0;
    flag_clr_data = 16'h0;
    irq_en_wr     = 1'b0;
    irq_en_data   = 16'h0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    fork
      begin
        t_set_and_read;
        t_burst_wrap;
        t_reject;
        t_irq_clear;
        t_priority;
      end
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) check(1'b0, "watchdog", 64'h0, 64'h1);
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule